// File: doc/BRIEF.md
# UART Receive Character Queue with Mode Control

This block is the receive-side character store of a 16550-compatible UART register model. It runs in two modes. In single-character mode, the mode after reset, it keeps exactly one character. In queue mode it keeps up to `DEPTH` characters in arrival order. The host picks the mode, and can flush the store, by writing the FIFO control register. The block keeps the part of that register that matters and shows it on an output.

Characters arrive from one of two sources. Normally they come from the serial receiver's character strobe. When loopback is selected, each host write to the transmit holding register becomes a received character, and the serial receiver is ignored. A host read of the data register removes the oldest character. The block reports how many characters are held, which the line status and interrupt logic use. It also raises a one-cycle overrun pulse when a character arrives while the store is full.

Top module: `uart_rxq`

## Requirements
- R1: After reset the character count is 0, the stored control value is 0x00, the read data is 0x00, the overrun pulse is low, and the store is in single-character mode.
- R2: A control write with bit 0 clear sets the stored control value to 0x00 from the next cycle, whatever the other bits are.
- R3: A control write with bit 0 set stores the written value ANDed with 0xC9 (enable bit 0, DMA-mode bit 3, trigger bits 7:6) from the next cycle.
- R4: A control write that changes bit 0 empties the store. The capacity becomes `DEPTH` if bit 0 is now set and 1 if it is clear.
- R5: A control write with bit 0 and bit 1 (receiver reset) both set empties the store. A control write with bit 0 clear while the block is already in single-character mode leaves the stored character in place, even if bit 1 is set.
- R6: In single-character mode one character is held. A second character that arrives before the read is dropped and raises the overrun pulse.
- R7: In queue mode up to `DEPTH` characters are returned in arrival order. A character that arrives while `DEPTH` are held is dropped, and the overrun pulse is high for the one cycle after that arrival.
- R8: A read while the store is empty leaves the count at 0, and the read data keeps the last character that was removed (0x00 if none has been removed).
- R9: When the store is neither empty nor full, an arrival and a read in the same cycle both take effect. The count is unchanged and the order is kept. While the count is nonzero, the read data shows the oldest held character.
- R10: With loopback selected, only transmit-holding writes add characters and receiver strobes are ignored. With loopback off, the reverse holds.
- R11: A control write that empties the store takes priority over an arrival or read in the same cycle. Both are discarded and the count is 0 afterwards.
- R12: The character count never exceeds the capacity of the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | FIFO control register write strobe |
| ctl_wdata | input | 8 | FIFO control register write value |
| loop_en | input | 1 | Loopback selected: the character source is transmit-holding writes |
| thr_wr | input | 1 | Transmit holding register write strobe |
| thr_wdata | input | 8 | Transmit holding register write value |
| rx_valid | input | 1 | Serial receiver character strobe |
| rx_char | input | 8 | Serial receiver character |
| data_rd | input | 1 | Data register read strobe; removes the oldest character |
| rd_char | output | 8 | Oldest held character, or last removed character when empty |
| char_count | output | $clog2(DEPTH+1) | Number of characters held |
| overrun_pulse | output | 1 | One-cycle pulse after an arrival that found the store full |
| ctl_value | output | 8 | Stored FIFO control value |

## Verification
The assertions assume that every strobe and data input is driven to a known value from reset onward. They also assume that each strobe asserted for one cycle stands for exactly one register access. The bench drives all inputs low during reset and changes them only one time unit after a rising edge. Random control writes are made rare, so the store has time to fill and overflow between flushes. Loopback is toggled with strobes from both sources active, which exercises the ignored path.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_RXCLR = 1;
  localparam logic [7:0]  CTL_KEEP  = 8'hC9;
  typedef logic [7:0] char_t;
endpackage

// File: rtl/rxq_mode_ctl.sv
module rxq_mode_ctl
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  char_t         wr_data,
  output char_t         ctl_q,
  output logic          flush,
  output logic [IW-1:0] last_idx
);
  char_t ctl_d;
  logic  en_change;

  always_comb begin
    en_change = wr_data[CTL_EN] ^ ctl_q[CTL_EN];
    flush     = wr_en && (en_change || (wr_data[CTL_EN] && wr_data[CTL_RXCLR]));
    ctl_d     = ctl_q;
    if (wr_en) begin
      if (wr_data[CTL_EN]) ctl_d = wr_data & CTL_KEEP;
      else                 ctl_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end

  assign last_idx = ctl_q[CTL_EN] ? IW'(DEPTH - 1) : '0;

  // R2: disabling write zeroes the stored value
  a_r2_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CTL_EN]) |=> (ctl_q == 8'h00));
  // R3: enabling write keeps only the retained fields
  a_r3_keep_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CTL_EN]) |=> (ctl_q == ($past(wr_data) & 8'hC9)));
endmodule

// File: rtl/rxq_src_sel.sv
module rxq_src_sel
  import uart_rxq_pkg::*;
(
  input  logic  loop_en,
  input  logic  thr_wr,
  input  char_t thr_wdata,
  input  logic  rx_valid,
  input  char_t rx_char,
  output logic  push,
  output char_t push_data
);
  always_comb begin
    if (loop_en) begin
      push      = thr_wr;
      push_data = thr_wdata;
    end else begin
      push      = rx_valid;
      push_data = rx_char;
    end
  end
endmodule

// File: rtl/rxq_ring.sv
module rxq_ring
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [IW-1:0] last_idx,
  input  logic          push,
  input  char_t         push_data,
  input  logic          pop,
  output logic [CW-1:0] count,
  output char_t         rd_char,
  output logic          ovr
);
  char_t         mem [DEPTH];
  logic [IW-1:0] rd_idx, wr_idx, rd_idx_d, wr_idx_d;
  logic [CW-1:0] count_d, cap;
  char_t         last_q;
  logic          empty, full, do_push, do_pop, ovr_d;

  function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] idx,
                                             input logic [IW-1:0] lim);
    return (idx == lim) ? '0 : idx + IW'(1);
  endfunction

  always_comb begin
    cap     = CW'(last_idx) + CW'(1);
    empty   = (count == '0);
    full    = (count == cap);
    do_push = push && !full && !flush;
    do_pop  = pop && !empty && !flush;
    ovr_d   = push && full && !flush;
    rd_idx_d = rd_idx;
    wr_idx_d = wr_idx;
    count_d  = count;
    if (flush) begin
      rd_idx_d = '0;
      wr_idx_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) wr_idx_d = step_idx(wr_idx, last_idx);
      if (do_pop)  rd_idx_d = step_idx(rd_idx, last_idx);
      case ({do_push, do_pop})
        2'b10:   count_d = count + CW'(1);
        2'b01:   count_d = count - CW'(1);
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= '0;
      wr_idx <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      rd_idx <= rd_idx_d;
      wr_idx <= wr_idx_d;
      count  <= count_d;
      ovr    <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= '0;
    else if (do_pop) last_q <= mem[rd_idx];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (do_push && (wr_idx == IW'(g))) mem[g] <= push_data;
    end
  end

  assign rd_char = empty ? last_q : mem[rd_idx];

  // R12: occupancy bounded by the active capacity
  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);
  // R4 / R11: a flush leaves the store empty
  a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R7: overrun only follows an arrival at full occupancy
  a_r7_ovr_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> ($past(count) == ($past(CW'(last_idx)) + CW'(1))));
  // R8: read on empty changes nothing
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty && !flush) |=> ((count == '0) && $stable(last_q)));
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          loop_en,
  input  logic          thr_wr,
  input  logic [7:0]    thr_wdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_char,
  input  logic          data_rd,
  output logic [7:0]    rd_char,
  output logic [CW-1:0] char_count,
  output logic          overrun_pulse,
  output logic [7:0]    ctl_value
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          flush, push;
  char_t         push_data;
  logic [IW-1:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rxq_mode_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (ctl_wr),
    .wr_data  (ctl_wdata),
    .ctl_q    (ctl_value),
    .flush    (flush),
    .last_idx (last_idx)
  );

  rxq_src_sel u_src (
    .loop_en   (loop_en),
    .thr_wr    (thr_wr),
    .thr_wdata (thr_wdata),
    .rx_valid  (rx_valid),
    .rx_char   (rx_char),
    .push      (push),
    .push_data (push_data)
  );

  rxq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush     (flush),
    .last_idx  (last_idx),
    .push      (push),
    .push_data (push_data),
    .pop       (data_rd),
    .count     (char_count),
    .rd_char   (rd_char),
    .ovr       (overrun_pulse)
  );

  // R10: with loopback, a receiver strobe alone does not add a character
  a_r10_loop_ignores_rx: assert property (@(posedge clk) disable iff (!rst_int_n)
    (loop_en && !thr_wr && rx_valid && !ctl_wr && !data_rd)
      |=> (char_count == $past(char_count)));
  // R6: in single-character mode the count stays at most one
  a_r6_single_cap: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_value[0] |-> (char_count <= CW'(1)));
endmodule

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, loop_en = 0, thr_wr = 0, rx_valid = 0, data_rd = 0;
  logic [7:0] ctl_wdata = 0, thr_wdata = 0, rx_char = 0;
  logic [7:0] rd_char, ctl_value;
  logic [CW-1:0] char_count;
  logic overrun_pulse;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  byte unsigned mq[$];
  byte unsigned m_last = 0, m_ctl = 0;
  bit m_ovr = 0;

  always #5 clk = ~clk;

  uart_rxq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .loop_en(loop_en), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .rx_valid(rx_valid), .rx_char(rx_char), .data_rd(data_rd),
    .rd_char(rd_char), .char_count(char_count),
    .overrun_pulse(overrun_pulse), .ctl_value(ctl_value)
  );

  function automatic int m_cap();
    return m_ctl[0] ? DEPTH : 1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // apply inputs for one cycle, update model, compare after the edge
  task automatic cyc(input bit cw, input byte unsigned cwd, input bit lp,
                     input bit tw, input byte unsigned td, input bit rv,
                     input byte unsigned rc, input bit pp, input string tag);
    bit clr, psh, full;
    byte unsigned pd;
    ctl_wr = cw; ctl_wdata = cwd; loop_en = lp; thr_wr = tw; thr_wdata = td;
    rx_valid = rv; rx_char = rc; data_rd = pp;
    @(posedge clk); #1;
    clr = cw && ((cwd[0] != m_ctl[0]) || (cwd[0] && cwd[1]));
    psh = lp ? tw : rv;
    pd  = lp ? td : rc;
    m_ovr = 0;
    if (clr) mq.delete();
    else begin
      full = (mq.size() == m_cap());
      if (psh && full) m_ovr = 1;
      if (pp && mq.size() > 0) m_last = mq.pop_front();
      if (psh && !full) mq.push_back(pd);
    end
    if (cw) m_ctl = cwd[0] ? (cwd & 8'hC9) : 8'h00;
    check(tag, "count", int'(char_count), mq.size());
    check(tag, "rd_char", int'(rd_char), mq.size() > 0 ? int'(mq[0]) : int'(m_last));
    check(tag, "overrun", int'(overrun_pulse), int'(m_ovr));
    check(tag, "ctl", int'(ctl_value), int'(m_ctl));
    ctl_wr = 0; thr_wr = 0; rx_valid = 0; data_rd = 0;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, loop_en, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rxp(input byte unsigned c, input string tag);
    cyc(0, 0, 0, 0, 0, 1, c, 0, tag);
  endtask
  task automatic rdp(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic cwr(input byte unsigned v, input string tag);
    cyc(1, v, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    idle("R1");
    // single-character mode
    rxp(8'h41, "R6"); rxp(8'h42, "R6"); idle("R6");
    rdp("R8"); rdp("R8"); rdp("R8");
    // disabled write with rxclr keeps held character
    rxp(8'h43, "R5"); cwr(8'h02, "R5"); idle("R5");
    // enabling clears
    cwr(8'h01, "R4");
    for (int i = 0; i <= DEPTH; i++) rxp(8'h60 + 8'(i), "R7");
    idle("R7");
    for (int i = 0; i < DEPTH; i++) rdp("R7");
    rdp("R8");
    for (int i = 0; i < 3; i++) rxp(8'h70 + 8'(i), "R9");
    cyc(0, 0, 0, 0, 0, 1, 8'h7A, 1, "R9");
    cyc(0, 0, 0, 0, 0, 1, 8'h7B, 1, "R9");
    cwr(8'h03, "R5"); idle("R5");
    rxp(8'h11, "R11");
    cyc(1, 8'hC3, 0, 0, 0, 1, 8'h12, 1, "R11");
    cwr(8'hFF, "R3"); cwr(8'hFE, "R2"); cwr(8'h0F, "R3"); cwr(8'h00, "R4");
    // loopback source selection
    cyc(0, 0, 1, 0, 0, 1, 8'h21, 0, "R10");
    cyc(0, 0, 1, 1, 8'h22, 1, 8'h23, 0, "R10");
    rdp("R10");
    cyc(0, 0, 0, 1, 8'h24, 0, 0, 0, "R10");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit cw, lp;
      byte unsigned v;
      cw = ($urandom % 40) == 0;
      v  = byte'($urandom);
      if (($urandom % 8) == 0) v[0] = ~m_ctl[0];
      lp = (($urandom % 64) == 0) ? ~loop_en : loop_en;
      cyc(cw, v, lp, ($urandom % 2) == 0, byte'($urandom), ($urandom % 2) == 0,
          byte'($urandom), ($urandom % 5) < 2, "R12");
    end
    finish_run();
  end
endmodule